// File: doc/BRIEF.md
# Dirty Band Update Coalescer

This block scans a frame that is tracked as a bitmap of dirty flags, one flag for each horizontal band of four display lines. It turns the dirty bands into as few screen updates as possible. A run of consecutive dirty bands becomes one update rectangle, given as a first line and a line count. Every rectangle spans the full display width, so the width is not carried in the record. The records leave through a valid/ready stream. While it scans, the block keeps track of the lowest and highest dirty band index. This lets the owner of the bitmap clear every touched flag in one bulk operation once the scan is over.

A scan begins with a one-cycle `start` pulse, which also samples the frame height in lines. The block reads the flags through a synchronous read port: it raises `flag_rd` with a band index on `flag_addr`, and the data is expected on `flag_data` in the next cycle. The record stream follows the usual rules. A record stays on `rec_valid` with stable fields until the cycle in which `rec_ready` is high. While a record waits, the scan is frozen and no flag reads are issued. After the last record, the clear range is shown for one cycle, provided any band was dirty, and `done` pulses in the cycle after that. `frame_lines` must not exceed `MAX_LINES`, and `MAX_LINES` must be a multiple of four.

Top module: `dirty_band_coalescer`

## Requirements
- R1: Band k covers lines 4k to 4k+3 and is read at flag address k. A scan reads bands 0 to ceil(frame_lines/4)-1 once each, in ascending order, and reads no band beyond these.
- R2: A dirty band (flag 1) that follows a clean band or the top of the frame opens a run whose start line is 4 times that band's index.
- R3: A clean band (flag 0) at index k that follows an open run emits a record with start equal to the run start and height 4k minus the run start. The run is then closed. Consecutive dirty bands never split into separate records.
- R4: A run still open when the scan ends is emitted with height 4*ceil(frame_lines/4) minus its start.
- R5: After the last record, `clr_valid` is high for exactly one cycle, with `clr_lo` and `clr_hi` set to the lowest and highest dirty band index. This happens only if at least one scanned band was dirty. Otherwise `clr_valid` stays low.
- R6: Each `start` re-initialises the run and range tracking, so nothing from an earlier scan affects a later one.
- R7: While `rec_valid` is high and `rec_ready` is low, the record fields stay stable and `flag_rd` stays low.
- R8: `done` is high for one cycle, once per scan. It comes one cycle after the clear-range cycle and after every record of the scan has been accepted.
- R9: After reset, `rec_valid`, `clr_valid`, `done` and `flag_rd` are all low.
- R10: With `frame_lines` equal to 0, a scan issues no reads, emits no records and no clear range, and still ends with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a scan. Sampled only when idle |
| frame_lines | input | LINE_W | Frame height in lines, sampled at `start` |
| flag_rd | output | 1 | Flag read request |
| flag_addr | output | BAND_W | Band index to read |
| flag_data | input | 1 | Dirty flag, valid one cycle after `flag_rd` |
| rec_valid | output | 1 | Update record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_start | output | LINE_W | First line of the update rectangle |
| rec_height | output | LINE_W | Line count of the update rectangle |
| clr_valid | output | 1 | Clear range present (one cycle) |
| clr_lo | output | BAND_W | Lowest dirty band index |
| clr_hi | output | BAND_W | Highest dirty band index |
| done | output | 1 | Scan finished (one cycle) |

## Verification
Each record is due at the clock edge where `rec_valid` and `rec_ready` are both high. The bench compares it there, in order, against a list computed from the bitmap pattern. It never compares against a fixed cycle number, so any stall pattern gives the same expected data. A read issued in one cycle supplies `flag_data` in the next, and a read address is checked in the cycle it is requested. The clear range is checked in its single valid cycle. `done` is checked to arrive exactly one cycle later, or on its own when nothing was dirty. All outputs are sampled on the falling edge, and the bench changes `rec_ready` just after the rising edge.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int LINES_PER_BAND = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_EVAL,
    ST_HOLD,
    ST_END,
    ST_CLR,
    ST_DONE
  } scan_st_e;
endpackage

// File: rtl/dbc_cursor.sv
module dbc_cursor #(
  parameter int LINE_W = 10,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [LINE_W-1:0] line
);
  localparam logic [LINE_W-1:0] STEP_V = LINE_W'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     line <= '0;
    else if (clear) line <= '0;
    else if (step)  line <= line + STEP_V;
  end
endmodule

// File: rtl/dbc_extent.sv
module dbc_extent #(
  parameter int BAND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              hit,
  input  logic [BAND_W-1:0] band,
  output logic [BAND_W-1:0] lo,
  output logic [BAND_W-1:0] hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '1;
      hi <= '0;
    end else if (clear) begin
      lo <= '1;
      hi <= '0;
    end else if (hit) begin
      if (band < lo) lo <= band;
      if (band > hi) hi <= band;
    end
  end
endmodule

// File: rtl/dirty_band_coalescer.sv
module dirty_band_coalescer
  import dbc_pkg::*;
#(
  parameter int MAX_LINES = 768,
  parameter int NBANDS    = MAX_LINES / LINES_PER_BAND,
  parameter int BAND_W    = $clog2(NBANDS),
  parameter int LINE_W    = $clog2(MAX_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LINE_W-1:0] frame_lines,
  output logic              flag_rd,
  output logic [BAND_W-1:0] flag_addr,
  input  logic              flag_data,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [LINE_W-1:0] rec_start,
  output logic [LINE_W-1:0] rec_height,
  output logic              clr_valid,
  output logic [BAND_W-1:0] clr_lo,
  output logic [BAND_W-1:0] clr_hi,
  output logic              done
);
  localparam int SHIFT = $clog2(LINES_PER_BAND);

  scan_st_e          st;
  logic [LINE_W-1:0] line;
  logic [LINE_W-1:0] frame_len;
  logic [LINE_W-1:0] run_start;
  logic              run_open;
  logic              hold_to_end;
  logic              launch;
  logic [BAND_W-1:0] cur_band;

  assign launch   = (st == ST_IDLE) && start;
  assign cur_band = BAND_W'(line >> SHIFT);

  dbc_cursor #(.LINE_W(LINE_W), .STEP(LINES_PER_BAND)) u_cursor (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (launch),
    .step  (st == ST_EVAL),
    .line  (line)
  );

  dbc_extent #(.BAND_W(BAND_W)) u_extent (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (launch),
    .hit   ((st == ST_EVAL) && flag_data),
    .band  (cur_band),
    .lo    (clr_lo),
    .hi    (clr_hi)
  );

  assign flag_rd   = (st == ST_REQ) && (line < frame_len);
  assign flag_addr = cur_band;
  assign clr_valid = (st == ST_CLR) && (clr_lo <= clr_hi);
  assign done      = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      frame_len   <= '0;
      run_start   <= '0;
      run_open    <= 1'b0;
      hold_to_end <= 1'b0;
      rec_valid   <= 1'b0;
      rec_start   <= '0;
      rec_height  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          frame_len <= frame_lines;
          run_open  <= 1'b0;
          st        <= ST_REQ;
        end
        ST_REQ: st <= (line < frame_len) ? ST_EVAL : ST_END;
        ST_EVAL: begin
          if (flag_data) begin
            if (!run_open) begin
              run_open  <= 1'b1;
              run_start <= line;
            end
            st <= ST_REQ;
          end else if (run_open) begin
            rec_valid   <= 1'b1;
            rec_start   <= run_start;
            rec_height  <= line - run_start;
            run_open    <= 1'b0;
            hold_to_end <= 1'b0;
            st          <= ST_HOLD;
          end else begin
            st <= ST_REQ;
          end
        end
        ST_HOLD: if (rec_ready) begin
          rec_valid <= 1'b0;
          st        <= hold_to_end ? ST_CLR : ST_REQ;
        end
        ST_END: begin
          if (run_open) begin
            rec_valid   <= 1'b1;
            rec_start   <= run_start;
            rec_height  <= line - run_start;
            run_open    <= 1'b0;
            hold_to_end <= 1'b1;
            st          <= ST_HOLD;
          end else begin
            st <= ST_CLR;
          end
        end
        ST_CLR:  st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: a waiting record keeps its fields
  p_rec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_start) && $stable(rec_height));

  // R7: scan frozen while a record waits
  p_no_read_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !flag_rd);

  // R3: heights are whole bands and never empty
  p_height_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_height != '0) && (rec_height[SHIFT-1:0] == '0));

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done follows the clear range
  p_clr_then_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> done);

  // R5: clear range is ordered and single-cycle
  p_clr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> (clr_lo <= clr_hi) && !rec_valid);

  p_clr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> !clr_valid);
endmodule

// File: tb/dirty_band_coalescer_test.sv
module dirty_band_coalescer_test;
  localparam int PERIOD = 10;
  localparam int MAXL   = 256;
  localparam int NB     = MAXL / 4;
  localparam int BW     = 6;
  localparam int LW     = 9;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LW-1:0] frame_lines = '0;
  logic flag_rd, flag_data = 1'b0, rec_valid, rec_ready = 1'b1;
  logic [BW-1:0] flag_addr, clr_lo, clr_hi;
  logic [LW-1:0] rec_start, rec_height;
  logic clr_valid, done;

  dirty_band_coalescer #(.MAX_LINES(MAXL)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_lines(frame_lines),
    .flag_rd(flag_rd), .flag_addr(flag_addr), .flag_data(flag_data),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_start(rec_start),
    .rec_height(rec_height), .clr_valid(clr_valid), .clr_lo(clr_lo),
    .clr_hi(clr_hi), .done(done));

  always #(PERIOD/2) clk = ~clk;

  logic [NB-1:0] bitmap = '0;
  always @(posedge clk) if (flag_rd) flag_data <= bitmap[flag_addr];

  int n_run = 0, n_fail = 0;
  int ready_mode = 0;
  int exp_s [0:NB-1];
  int exp_h [0:NB-1];
  int exp_n, exp_lo, exp_hi, exp_nb;
  bit exp_clr;
  int rec_idx, rd_cnt, rd_pend, done_cnt, clr_cnt, clr_cyc, done_cyc, cyc;

  // {stall, lines, pattern}
  localparam logic [73:0] VECS [0:7] = '{
    {1'b0, 9'd256, 64'h0},                    // R3 nothing dirty
    {1'b0, 9'd256, 64'h1},                    // R2 R3 first band only
    {1'b1, 9'd256, 64'hFFFF_FFFF_FFFF_FFFF},  // R4 one run to the end
    {1'b0, 9'd256, 64'h20},                   // R6 range re-initialised
    {1'b1, 9'd256, 64'h8000_0000_0000_0000},  // R4 last band only
    {1'b1, 9'd256, 64'h0000_0000_00F0_0F0D},  // R2 R3 several runs
    {1'b0, 9'd30,  64'hFFFF_FFFF_FFFF_FFFF},  // R1 partial band at end
    {1'b0, 9'd0,   64'hFFFF_FFFF_FFFF_FFFF}   // R10 empty frame
  };

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // ready driver, changes just after the rising edge
  initial forever begin
    @(posedge clk); #1;
    rec_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? ~rec_ready : 1'b0;
  end

  // monitor on the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    if (flag_rd) begin
      chk(int'(flag_addr) == rd_cnt && rd_cnt < exp_nb, "R1 read address", flag_addr, rd_cnt);
      rd_cnt++;
      if (rec_valid) rd_pend++;
    end
    if (rec_valid && rec_ready) begin
      if (rec_idx < exp_n) begin
        chk(int'(rec_start) == exp_s[rec_idx], "R2 record start", rec_start, exp_s[rec_idx]);
        chk(int'(rec_height) == exp_h[rec_idx], "R3 R4 record height", rec_height, exp_h[rec_idx]);
      end else chk(0, "R3 extra record", rec_idx, exp_n);
      rec_idx++;
    end
    if (clr_valid) begin
      clr_cnt++; clr_cyc = cyc;
      chk(int'(clr_lo) == exp_lo, "R5 clear low", clr_lo, exp_lo);
      chk(int'(clr_hi) == exp_hi, "R5 clear high", clr_hi, exp_hi);
    end
    if (done) begin done_cnt++; done_cyc = cyc; end
  end

  task automatic model(input int lines, input logic [NB-1:0] pat);
    bit open = 0; int st = 0;
    exp_nb = (lines + 3) / 4; exp_n = 0; exp_lo = NB; exp_hi = -1;
    for (int k = 0; k < exp_nb; k++) begin
      if (pat[k]) begin
        if (!open) begin open = 1; st = 4*k; end
        if (k < exp_lo) exp_lo = k;
        if (k > exp_hi) exp_hi = k;
      end else if (open) begin
        exp_s[exp_n] = st; exp_h[exp_n] = 4*k - st; exp_n++; open = 0;
      end
    end
    if (open) begin exp_s[exp_n] = st; exp_h[exp_n] = 4*exp_nb - st; exp_n++; end
    exp_clr = (exp_hi >= 0);
  endtask

  task automatic launch(input int lines, input logic [NB-1:0] pat);
    model(lines, pat);
    bitmap = pat; frame_lines = LW'(lines);
    rec_idx = 0; rd_cnt = 0; rd_pend = 0; done_cnt = 0; clr_cnt = 0;
    clr_cyc = -10; done_cyc = -10;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_scan(input string tag);
    int guard = 0;
    while (done_cnt == 0 && guard < 3000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R8 single done", done_cnt, 1);
    chk(rec_idx == exp_n, "R3 record count", rec_idx, exp_n);
    chk(rd_cnt == exp_nb, "R1 R10 read count", rd_cnt, exp_nb);
    chk(clr_cnt == int'(exp_clr), "R5 clear presence", clr_cnt, int'(exp_clr));
    if (exp_clr) chk(done_cyc == clr_cyc + 1, "R8 done after clear", done_cyc, clr_cyc + 1);
    chk(rd_pend == 0, "R7 read while pending", rd_pend, 0);
    if (tag.len() == 0) ;
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!rec_valid && !clr_valid && !done && !flag_rd, "R9 reset idle",
        {rec_valid, clr_valid, done, flag_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rec_valid && !clr_valid && !done && !flag_rd, "R9 idle after reset",
        {rec_valid, clr_valid, done, flag_rd}, 0);

    for (int v = 0; v < 8; v++) begin
      ready_mode = VECS[v][73] ? 1 : 0;
      launch(int'(VECS[v][72:64]), VECS[v][63:0]);
      finish_scan("vec");
    end
    ready_mode = 0;

    // R7 directed: record held under back-pressure
    ready_mode = 2;
    repeat (2) @(negedge clk);
    launch(256, 64'h6);
    begin
      int g = 0;
      while (!rec_valid && g < 500) begin @(negedge clk); g++; end
    end
    repeat (6) @(negedge clk);
    chk(rec_valid == 1'b1, "R7 valid held", rec_valid, 1);
    chk(int'(rec_start) == 4 && int'(rec_height) == 8, "R7 fields stable", rec_start, 4);
    chk(rec_idx == 0, "R7 no transfer while stalled", rec_idx, 0);
    ready_mode = 0;
    finish_scan("stall");

    // R6 directed: range after a wide scan then a single band
    launch(256, 64'hFFFF_FFFF_FFFF_FFFF);
    finish_scan("wide");
    launch(256, 64'h0000_0400_0000_0000);
    finish_scan("narrow");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule